// File: doc/BRIEF.md
# Register-Mapped Pin Controller with Flash and Temperature-Sensor Lines

This block gives a processor two 32-bit general-purpose ports, called A and D, behind a small word-addressed register bus. Each port has an output-value word, an input-view word and a drive-enable word. Every other word in the window is plain scratch storage. A few bits are wired straight to board peripherals. Three output bits of port A drive the control strobes of a parallel flash device, and one input bit of port A shows that device's ready line. On port D, software bit-bangs a serial temperature sensor: it writes the clock and data bits, and it reads the sensor's reply line back through the port D input view.

Reading an input-view word returns the output value masked by the drive enables, with the live peripheral line merged in at its fixed bit. A write to the port D output word that flips the sensor clock bit also gives a one-cycle edge pulse, tagged rising or falling. A sensor-side shifter can therefore act on real clock transitions instead of on every store.

Top module: `gpio_pin_hub`

## Requirements
- R1: After reset every stored word is zero, so rdata, all flash strobes, the sensor clock and data lines and the edge pulse are 0, and a read of any index returns 0 apart from the merged peripheral bits.
- R2: A write to an in-range, aligned index stores the whole 32-bit word. Every index other than 1 and 17 reads back the last value written there.
- R3: An access whose word index (byte address >> 2) is 23 or more is ignored. A write there changes no stored word and no output, and a read returns 0.
- R4: An access whose byte address has bits [1:0] non-zero is ignored. A write changes nothing, and a read returns 0.
- R5: A read of index 1 returns (word 0 AND word 2) with bit 7 replaced by the flash_rdy_i level sampled at the read edge.
- R6: A read of index 17 returns (word 16 AND word 18) ORed with the sens_sdo_i level at bit 4.
- R7: flash_ale_o, flash_cle_o and flash_ce_o follow bits 6, 5 and 4 of word 0 from the cycle after the write that stores it.
- R8: sens_edge_o is high for exactly the one cycle after an accepted write to index 16 whose bit 1 differs from the stored bit 1. It stays low after any other write.
- R9: sens_rise_o is high together with sens_edge_o when the new clock bit is 1. It is low on a falling edge and whenever no edge is flagged.
- R10: sens_sck_o and sens_sdi_o follow bits 1 and 4 of word 16 from the cycle after the write that stores it.
- R11: rdata updates in the cycle after rd_en is sampled high and holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (8) | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| flash_rdy_i | input | 1 | Flash ready line |
| flash_ale_o | output | 1 | Flash address latch strobe |
| flash_cle_o | output | 1 | Flash command latch strobe |
| flash_ce_o | output | 1 | Flash chip enable |
| sens_sdo_i | input | 1 | Sensor serial reply line |
| sens_sck_o | output | 1 | Sensor clock level |
| sens_sdi_o | output | 1 | Sensor serial data line |
| sens_edge_o | output | 1 | One-cycle pulse on a sensor clock change |
| sens_rise_o | output | 1 | Direction of the flagged edge (1 = rising) |

## Verification
A corrupted stored word shows up on the next read of its index, or of the input view that masks it, one cycle after rd_en. For words 0 and 16 it shows up sooner, on the strobe and sensor pins in the cycle right after the write. A wrong stored clock bit causes an edge pulse to be missed or spurious on the next port D write, and that is visible in that same following cycle. A decode fault that lets an ignored access through only shows once the damaged word is read again, so the stimulus reads back often and covers every index.

// File: rtl/gph_pkg.sv
package gph_pkg;
  localparam int unsigned DATA_W     = 32;
  // word indices whose behaviour differs from plain storage
  localparam int unsigned IDX_PA_OUT = 0;
  localparam int unsigned IDX_PA_IN  = 1;
  localparam int unsigned IDX_PA_OE  = 2;
  localparam int unsigned IDX_PD_OUT = 16;
  localparam int unsigned IDX_PD_IN  = 17;
  localparam int unsigned IDX_PD_OE  = 18;
  // bit positions of peripheral lines
  localparam int unsigned BIT_RDY    = 7;
  localparam int unsigned BIT_ALE    = 6;
  localparam int unsigned BIT_CLE    = 5;
  localparam int unsigned BIT_CE     = 4;
  localparam int unsigned BIT_SCK    = 1;
  localparam int unsigned BIT_SDI    = 4;
  localparam int unsigned BIT_SDO    = 4;
endpackage

// File: rtl/gph_addr_dec.sv
module gph_addr_dec #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_WORDS = 23,
  localparam int unsigned IDX_W    = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              hit
);
  logic aligned;
  logic in_range;

  always_comb begin
    idx      = addr[ADDR_W-1:2];
    aligned  = (addr[1:0] == 2'b00);
    in_range = (int'(idx) < int'(NUM_WORDS));
    hit      = aligned && in_range;
  end
endmodule

// File: rtl/gph_regbank.sv
module gph_regbank #(
  parameter int unsigned NUM_WORDS = 23,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IDX_W     = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [IDX_W-1:0]                 widx,
  input  logic [DATA_W-1:0]                wdata,
  output logic [NUM_WORDS-1:0][DATA_W-1:0] q
);
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    logic              wen;
    logic [DATA_W-1:0] word_d;
    logic [DATA_W-1:0] word_q;

    always_comb begin
      wen    = we && (widx == IDX_W'(i));
      word_d = wen ? wdata : word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (wen) begin
        word_q <= word_d;
      end
    end

    assign q[i] = word_q;
  end
endmodule

// File: rtl/gph_clk_edge.sv
module gph_clk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_pd,
  input  logic new_bit,
  input  logic old_bit,
  output logic edge_o,
  output logic rise_o
);
  logic edge_d;
  logic rise_d;

  always_comb begin
    edge_d = wr_pd && (new_bit != old_bit);
    rise_d = edge_d && new_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_o <= 1'b0;
      rise_o <= 1'b0;
    end else begin
      edge_o <= edge_d;
      rise_o <= rise_d;
    end
  end
endmodule

// File: rtl/gpio_pin_hub.sv
module gpio_pin_hub
  import gph_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_WORDS = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              flash_rdy_i,
  output logic              flash_ale_o,
  output logic              flash_cle_o,
  output logic              flash_ce_o,
  input  logic              sens_sdo_i,
  output logic              sens_sck_o,
  output logic              sens_sdi_o,
  output logic              sens_edge_o,
  output logic              sens_rise_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]                 idx;
  logic                             hit;
  logic                             we;
  logic                             wr_pd;
  logic [NUM_WORDS-1:0][DATA_W-1:0] words;
  logic [DATA_W-1:0]                rd_next;
  logic [DATA_W-1:0]                pa_view;
  logic [DATA_W-1:0]                pd_view;

  gph_addr_dec #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_dec (
    .addr (addr),
    .idx  (idx),
    .hit  (hit)
  );

  assign we    = wr_en && hit;
  assign wr_pd = we && (idx == IDX_W'(IDX_PD_OUT));

  gph_regbank #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .widx  (idx),
    .wdata (wdata),
    .q     (words)
  );

  gph_clk_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_pd   (wr_pd),
    .new_bit (wdata[BIT_SCK]),
    .old_bit (words[IDX_PD_OUT][BIT_SCK]),
    .edge_o  (sens_edge_o),
    .rise_o  (sens_rise_o)
  );

  // peripheral pins driven from stored output words
  assign flash_ale_o = words[IDX_PA_OUT][BIT_ALE];
  assign flash_cle_o = words[IDX_PA_OUT][BIT_CLE];
  assign flash_ce_o  = words[IDX_PA_OUT][BIT_CE];
  assign sens_sck_o  = words[IDX_PD_OUT][BIT_SCK];
  assign sens_sdi_o  = words[IDX_PD_OUT][BIT_SDI];

  // input views: masked output with live lines merged
  always_comb begin
    pa_view          = words[IDX_PA_OUT] & words[IDX_PA_OE];
    pa_view[BIT_RDY] = flash_rdy_i;
    pd_view          = words[IDX_PD_OUT] & words[IDX_PD_OE];
    pd_view[BIT_SDO] = pd_view[BIT_SDO] | sens_sdo_i;
  end

  always_comb begin
    rd_next = '0;
    if (hit) begin
      for (int i = 0; i < int'(NUM_WORDS); i++) begin
        if (idx == IDX_W'(i)) rd_next = words[i];
      end
      if (idx == IDX_W'(IDX_PA_IN)) rd_next = pa_view;
      if (idx == IDX_W'(IDX_PD_IN)) rd_next = pd_view;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_next;
    end
  end
endmodule

// File: rtl/gph_checker.sv
module gph_checker #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_WORDS = 23
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata,
  input logic              flash_ale_o,
  input logic              flash_cle_o,
  input logic              flash_ce_o,
  input logic              sens_sck_o,
  input logic              sens_sdi_o,
  input logic              sens_edge_o,
  input logic              sens_rise_o
);
  assert_edge_changes_clk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sens_edge_o |-> (sens_sck_o != $past(sens_sck_o)));

  assert_clk_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sens_edge_o |-> $stable(sens_sck_o));

  assert_rise_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sens_rise_o |-> (sens_edge_o && sens_sck_o));

  assert_strobe_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable({flash_ale_o, flash_cle_o, flash_ce_o, sens_sdi_o}));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rdata));

  assert_oob_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(addr[ADDR_W-1:2]) >= int'(NUM_WORDS))) |=> !sens_edge_o);

  assert_misaligned_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr[1:0] != 2'b00)) |=> !sens_edge_o);
endmodule

bind gpio_pin_hub gph_checker #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_chk (.*);

// File: tb/gpio_pin_hub_bench.sv
`timescale 1ns/1ps
module gpio_pin_hub_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        flash_rdy_i, sens_sdo_i;
  logic        flash_ale_o, flash_cle_o, flash_ce_o;
  logic        sens_sck_o, sens_sdi_o, sens_edge_o, sens_rise_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [0:22];

  always #2 clk = ~clk;

  gpio_pin_hub u_gpio_pin_hub (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .flash_rdy_i(flash_rdy_i),
    .flash_ale_o(flash_ale_o), .flash_cle_o(flash_cle_o), .flash_ce_o(flash_ce_o),
    .sens_sdo_i(sens_sdo_i), .sens_sck_o(sens_sck_o), .sens_sdi_o(sens_sdi_o),
    .sens_edge_o(sens_edge_o), .sens_rise_o(sens_rise_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a, input logic rdy, input logic sdo);
    int idx = int'(a[7:2]);
    if (a[1:0] != 2'b00 || idx >= 23) return 32'h0;
    if (idx == 1)  return ((mdl[0] & mdl[2]) & ~32'h80) | {24'h0, rdy, 7'h0};
    if (idx == 17) return (mdl[16] & mdl[18]) | {27'h0, sdo, 4'h0};
    return mdl[idx];
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    int idx = int'(a[7:2]);
    if (a[1:0] != 2'b00) return "R4";
    if (idx >= 23) return "R3";
    if (idx == 1) return "R5";
    if (idx == 17) return "R6";
    return "R2";
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    int   idx = int'(a[7:2]);
    logic e_edge, e_rise;
    e_edge = 1'b0;
    e_rise = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a[1:0] == 2'b00 && idx < 23) begin
      if (idx == 16) begin
        e_edge = mdl[16][1] ^ d[1];
        e_rise = e_edge & d[1];
      end
      mdl[idx] = d;
    end
    chk("R8 edge pulse", {31'h0, sens_edge_o}, {31'h0, e_edge});
    chk("R9 edge direction", {31'h0, sens_rise_o}, {31'h0, e_rise});
    chk("R10 sensor lines", {30'h0, sens_sck_o, sens_sdi_o}, {30'h0, mdl[16][1], mdl[16][4]});
    chk("R7 flash strobes", {29'h0, flash_ale_o, flash_cle_o, flash_ce_o}, {29'h0, mdl[0][6:4]});
  endtask

  task automatic rd(input logic [7:0] a, input logic rdy, input logic sdo);
    logic [31:0] e;
    @(negedge clk);
    rd_en = 1'b1; addr = a; flash_rdy_i = rdy; sens_sdo_i = sdo;
    e = exp_rd(a, rdy, sdo);
    @(negedge clk);
    rd_en = 1'b0;
    chk({rd_tag(a), " read data"}, rdata, e);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 23; i++) mdl[i] = 32'h0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    flash_rdy_i = 1'b0; sens_sdo_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 pins", {25'h0, flash_ale_o, flash_cle_o, flash_ce_o, sens_sck_o,
                    sens_sdi_o, sens_edge_o, sens_rise_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h0C, 1'b0, 1'b0);            // R1 plain word reads zero
    rd(8'h04, 1'b0, 1'b0);            // R1/R5 input view zero
    rd(8'h44, 1'b0, 1'b1);            // R6 sdo only
    // R2 storage
    wr(8'h0C, 32'hDEADBEEF);
    rd(8'h0C, 1'b0, 1'b0);
    wr(8'h58, 32'h12345678);          // index 22, last in range
    rd(8'h58, 1'b0, 1'b0);
    // R3 out of range
    wr(8'h5C, 32'hFFFFFFFF);
    rd(8'h5C, 1'b0, 1'b0);
    rd(8'h58, 1'b0, 1'b0);
    wr(8'hFC, 32'h00000002);
    // R4 misaligned
    wr(8'h0D, 32'h0);
    rd(8'h0C, 1'b0, 1'b0);
    rd(8'h0E, 1'b0, 1'b0);
    wr(8'h42, 32'h2);                 // misaligned hit on port D word: no edge
    // R7 strobes
    wr(8'h00, 32'h00000070);
    wr(8'h00, 32'h00000020);
    // R5 input view
    wr(8'h00, 32'h000000FF);
    wr(8'h08, 32'hFFFF0F0F);
    rd(8'h04, 1'b1, 1'b0);
    rd(8'h04, 1'b0, 1'b0);
    // R6, R8, R9, R10 sensor sequence
    wr(8'h48, 32'hFFFFFFFF);
    wr(8'h40, 32'h00000002);          // rising
    wr(8'h40, 32'h00000012);          // no change
    wr(8'h40, 32'h00000010);          // falling
    rd(8'h44, 1'b0, 1'b0);
    rd(8'h44, 1'b0, 1'b1);
    // R11 hold
    rd(8'h0C, 1'b0, 1'b0);
    held = rdata;
    addr = 8'h58;
    repeat (3) @(negedge clk);
    chk("R11 hold", rdata, held);
    // random phase
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      int pick = int'($urandom_range(0, 9));
      if (pick < 6) a = {$urandom_range(0, 24) % 64, 2'b00};
      else if (pick < 8) a = {6'($urandom_range(16, 18)), 2'b00};
      else a = 8'($urandom);
      if ($urandom_range(0, 1) == 0) wr(a, $urandom);
      else rd(a, 1'($urandom), 1'($urandom));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule